// File: doc/BRIEF.md
# Address-Indexed Photon Counter Bank

This block keeps one photon count per pixel for a small detector array made of independent columns. Each column's capture logic hands the block a stream of row addresses, one per detected photon. The block queues every column's events on its own. It picks one queued event per clock in rotating column order and forms a counter index from the column number and the row. It then raises that counter by one through a read-modify-write of an on-chip counter memory.

A host starts a frame readout with a one-cycle command. The block stops taking events out of the column queues and finishes any increment already in flight. It then streams every counter, in index order, over a valid/ready read port, and zeroes each counter once it has been taken. After the last word counting resumes. While a readout runs, events still enter the column queues when there is room, and they are counted into the next frame.

Event side: `ev_ready` shows that a column queue has room. An event presented while `ev_ready` is low is not stalled. It is discarded and counted in that column's drop counter. Readout side: a word is transferred on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid`, `rd_data` and `rd_last` hold their values. The host may throttle the readout without limit.

Top module: `pcb_photon_counter`

## Requirements
- R1: After reset the block clears every counter with an internal sweep. During the sweep `frame_busy` is 1, and afterwards it is 0. All drop counters read 0, every `ev_ready` is 1 and `rd_valid` is 0.
- R2: An event on column c with row r below NROW (default 112) raises the counter at index {c, r} by one. Column c occupies bits [ROW_W-1:0] of slice c of `ev_row`.
- R3: A counter stops at its all-ones value (2^CNT_W-1) and does not wrap.
- R4: An event whose row is NROW or above has no effect. No counter changes, the drop counter does not change and the queue does not fill.
- R5: Each column queue holds QDEPTH events (default 2), and `ev_ready` is 1 exactly when that queue is not full. A valid event with a legal row that is presented while `ev_ready` is 0 is discarded. It adds one to that column's DROP_W-bit drop counter (slice c of `drop_cnt`), which stops at 255 by default.
- R6: At most one queued event is counted per clock. A column with a waiting event is served within NCOL grants, by a rotating choice that starts at column 0 after reset.
- R7: A `frame_req` pulse while `frame_busy` is 0 starts a frame readout. `frame_busy` rises on the next cycle. Exactly NCOL*NROW words follow, with `rd_last` set only on the final word. Column 0 comes first, and within a column the rows run from 0 upward. `frame_busy` returns to 0 after the final transfer. A `frame_req` that arrives while `frame_busy` is 1 is ignored.
- R8: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` and `rd_last` stay unchanged on the next cycle.
- R9: Each counter reads 0 in the frame after the one in which it was read out. Events accepted while a readout is in progress are counted after it, in the next frame.
- R10: Events that hit the same counter on consecutive clocks are each counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | NCOL | Per-column photon event strobe |
| ev_row | input | NCOL*ROW_W | Per-column row address of the event |
| ev_ready | output | NCOL | Column queue has room (event otherwise dropped) |
| drop_cnt | output | NCOL*DROP_W | Per-column saturating count of dropped events |
| frame_req | input | 1 | Start frame readout (pulse) |
| frame_busy | output | 1 | Sweep or readout in progress, counting paused |
| rd_valid | output | 1 | Readout word present |
| rd_ready | input | 1 | Host takes the readout word |
| rd_data | output | CNT_W | Counter value |
| rd_last | output | 1 | Marks the final word of the frame |

## Verification
Two pairs of activity can fall in the same clock. The first is an increment of a counter and the update of that same counter issued one cycle earlier, whose result is still being written. The second is a column event arriving while the frame readout is streaming. The first pair is provoked by trains of events to one pixel on back-to-back clocks, and by long single-pixel runs that push a counter into saturation. Both are judged by the exact value that pixel shows in the next readout. The second pair is provoked by driving one column on every clock of a throttled readout. It is judged by the drop count, by the readout words matching the snapshot taken at the command, and by the queued events showing up in the following frame.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Control sequencer states of the counter bank
  typedef enum logic [2:0] {
    ST_INIT   = 3'd0,  // post-reset clearing sweep
    ST_COUNT  = 3'd1,  // normal event counting
    ST_FLUSH  = 3'd2,  // let the in-flight increment land
    ST_RSTART = 3'd3,  // first readout fetch
    ST_READ   = 3'd4   // streaming words to the host
  } ctl_state_e;

endpackage

// File: rtl/pcb_evq.sv
module pcb_evq #(
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned NROW   = 112,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ROW_W-1:0]  in_row,
  output logic              in_ready,
  output logic              out_valid,
  output logic [ROW_W-1:0]  out_row,
  input  logic              out_pop,
  output logic [DROP_W-1:0] drop_cnt
);

  localparam int unsigned    PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned    OW       = $clog2(DEPTH + 1);
  localparam logic [ROW_W:0] ROW_LIM  = (ROW_W + 1)'(NROW);
  localparam logic [PW-1:0]  PTR_LAST = PW'(DEPTH - 1);
  localparam logic [OW-1:0]  OCC_FULL = OW'(DEPTH);

  logic [ROW_W-1:0] slot [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [OW-1:0]    occ;
  logic             row_ok, push, pop, drop;

  // rows outside the array are simply not seen
  assign row_ok    = {1'b0, in_row} < ROW_LIM;
  assign in_ready  = (occ != OCC_FULL);
  assign push      = in_valid && row_ok && in_ready;
  assign drop      = in_valid && row_ok && !in_ready;
  assign out_valid = (occ != '0);
  assign out_row   = slot[rp];
  assign pop       = out_pop && out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      occ      <= '0;
      drop_cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: ;
      endcase
      if (drop && (drop_cnt != '1)) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= in_row;
  end

  // R5: occupancy never passes the queue depth
  p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_FULL);

  // R5: a saturated drop counter stays saturated
  p_drop_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt == '1) |=> (drop_cnt == '1));

  // R6: the arbiter only takes from a non-empty queue
  p_pop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_pop |-> out_valid);

endmodule

// File: rtl/pcb_rr_arb.sv
module pcb_rr_arb #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx
);

  logic [IW-1:0] last;
  logic [IW-1:0] cand;
  logic          found;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    found     = 1'b0;
    cand      = '0;
    for (int k = 1; k <= int'(N); k++) begin
      cand = IW'((int'(last) + k) % int'(N));
      if (en && !found && req[cand]) begin
        grant[cand] = 1'b1;
        grant_idx   = cand;
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last <= IW'(N - 1);
    else if (found) last <= grant_idx;
  end

  // R6: at most one column per cycle
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: a grant always answers a request
  p_grant_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/pcb_cnt_ram.sv
module pcb_cnt_ram #(
  parameter int unsigned AW = 9,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  localparam int unsigned WORDS = 1 << AW;

  logic [W-1:0] mem [WORDS];

  // registered read, old data on a same-address write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pcb_photon_counter.sv
module pcb_photon_counter
  import pcb_pkg::*;
#(
  parameter int unsigned NCOL   = 4,
  parameter int unsigned NROW   = 112,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned QDEPTH = 2,
  parameter int unsigned DROP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCOL-1:0]        ev_valid,
  input  logic [NCOL*ROW_W-1:0]  ev_row,
  output logic [NCOL-1:0]        ev_ready,
  output logic [NCOL*DROP_W-1:0] drop_cnt,
  input  logic                   frame_req,
  output logic                   frame_busy,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [CNT_W-1:0]       rd_data,
  output logic                   rd_last
);

  localparam int unsigned      COL_W    = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int unsigned      AW       = COL_W + ROW_W;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOL - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NROW - 1);

  ctl_state_e state;

  // column queues
  logic [NCOL-1:0]  q_valid;
  logic [ROW_W-1:0] q_row [NCOL];
  logic [NCOL-1:0]  grant;
  logic [COL_W-1:0] gidx;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    pcb_evq #(
      .ROW_W (ROW_W),
      .NROW  (NROW),
      .DEPTH (QDEPTH),
      .DROP_W(DROP_W)
    ) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (ev_valid[c]),
      .in_row   (ev_row[c*ROW_W +: ROW_W]),
      .in_ready (ev_ready[c]),
      .out_valid(q_valid[c]),
      .out_row  (q_row[c]),
      .out_pop  (grant[c]),
      .drop_cnt (drop_cnt[c*DROP_W +: DROP_W])
    );
  end

  pcb_rr_arb #(.N(NCOL)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (q_valid),
    .en       (state == ST_COUNT),
    .grant    (grant),
    .grant_idx(gidx)
  );

  // counter memory
  logic [AW-1:0]    ram_raddr, ram_waddr;
  logic [CNT_W-1:0] ram_rdata, ram_wdata;
  logic             ram_we;

  pcb_cnt_ram #(.AW(AW), .W(CNT_W)) u_ram (
    .clk  (clk),
    .raddr(ram_raddr),
    .rdata(ram_rdata),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata)
  );

  // increment pipeline: stage 0 reads, stage 1 writes back
  logic [AW-1:0]    inc_addr, s1_addr, pw_addr;
  logic             s1_valid, pw_valid;
  logic [CNT_W-1:0] pw_data, old_val, inc_val;

  assign inc_addr = {gidx, q_row[gidx]};
  // the previous write is invisible to a read issued in the same cycle
  assign old_val  = (pw_valid && (pw_addr == s1_addr)) ? pw_data : ram_rdata;
  assign inc_val  = (&old_val) ? old_val : old_val + 1'b1;

  // sweep pointer used by the clearing sweep and by the readout
  logic [COL_W-1:0] sw_col, sw_col_nxt;
  logic [ROW_W-1:0] sw_row, sw_row_nxt;
  logic             sw_last;

  assign sw_last = (sw_col == LAST_COL) && (sw_row == LAST_ROW);

  always_comb begin
    if (sw_row == LAST_ROW) begin
      sw_row_nxt = '0;
      sw_col_nxt = sw_col + 1'b1;
    end else begin
      sw_row_nxt = sw_row + 1'b1;
      sw_col_nxt = sw_col;
    end
  end

  always_comb begin
    ram_raddr = inc_addr;
    ram_we    = 1'b0;
    ram_waddr = s1_addr;
    ram_wdata = inc_val;
    case (state)
      ST_INIT: begin
        ram_we    = 1'b1;
        ram_waddr = {sw_col, sw_row};
        ram_wdata = '0;
      end
      ST_COUNT, ST_FLUSH: ram_we = s1_valid;
      ST_RSTART: ram_raddr = {sw_col, sw_row};
      ST_READ: begin
        ram_raddr = rd_ready ? {sw_col_nxt, sw_row_nxt} : {sw_col, sw_row};
        ram_we    = rd_ready;
        ram_waddr = {sw_col, sw_row};
        ram_wdata = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      sw_col   <= '0;
      sw_row   <= '0;
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      pw_valid <= 1'b0;
      pw_addr  <= '0;
      pw_data  <= '0;
    end else begin
      s1_valid <= |grant;
      s1_addr  <= inc_addr;
      pw_valid <= ram_we;
      pw_addr  <= ram_waddr;
      pw_data  <= ram_wdata;
      case (state)
        ST_INIT: begin
          if (sw_last) begin
            state  <= ST_COUNT;
            sw_col <= '0;
            sw_row <= '0;
          end else begin
            sw_col <= sw_col_nxt;
            sw_row <= sw_row_nxt;
          end
        end
        ST_COUNT:  if (frame_req) state <= ST_FLUSH;
        ST_FLUSH:  state <= ST_RSTART;
        ST_RSTART: state <= ST_READ;
        ST_READ: begin
          if (rd_ready) begin
            if (sw_last) begin
              state  <= ST_COUNT;
              sw_col <= '0;
              sw_row <= '0;
            end else begin
              sw_col <= sw_col_nxt;
              sw_row <= sw_row_nxt;
            end
          end
        end
        default: state <= ST_INIT;
      endcase
    end
  end

  assign frame_busy = (state != ST_COUNT);
  assign rd_valid   = (state == ST_READ);
  assign rd_data    = ram_rdata;
  assign rd_last    = rd_valid && sw_last;

  // R8: a stalled word is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

  // R7: the marked word closes the frame
  p_last_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last) |=> (!rd_valid && !frame_busy));

  // R3: a written-back count never wraps to zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (inc_val != '0));

  // R9: no increment is issued while a readout is under way
  p_no_inc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (grant == '0));

endmodule

// File: tb/pcb_photon_counter_tb_top.sv
module pcb_photon_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCOL   = 4;
  localparam int NROW   = 112;
  localparam int ROW_W  = 7;
  localparam int CNT_W  = 10;
  localparam int QDEPTH = 2;
  localparam int DROP_W = 8;
  localparam int TOTAL  = NCOL * NROW;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int DMAX   = (1 << DROP_W) - 1;
  localparam int WDOG   = 100000;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NCOL-1:0]        ev_valid = '0;
  logic [NCOL*ROW_W-1:0]  ev_row = '0;
  logic [NCOL-1:0]        ev_ready;
  logic [NCOL*DROP_W-1:0] drop_cnt;
  logic                   frame_req = 1'b0;
  logic                   frame_busy;
  logic                   rd_valid;
  logic                   rd_ready = 1'b0;
  logic [CNT_W-1:0]       rd_data;
  logic                   rd_last;

  int errors = 0;
  int checks = 0;
  int exp_cnt [NCOL][NROW];
  int snap    [NCOL][NROW];
  int exp_drop[NCOL];
  int acc     [NCOL];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcb_photon_counter #(
    .NCOL(NCOL), .NROW(NROW), .ROW_W(ROW_W),
    .CNT_W(CNT_W), .QDEPTH(QDEPTH), .DROP_W(DROP_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_row(ev_row), .ev_ready(ev_ready),
    .drop_cnt(drop_cnt),
    .frame_req(frame_req), .frame_busy(frame_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic int sat_c(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int sat_d(input int v);
    return (v > DMAX) ? DMAX : v;
  endfunction

  function automatic logic [NCOL*ROW_W-1:0] mk_rows(input int r0, input int r1,
                                                    input int r2, input int r3);
    return {ROW_W'(r3), ROW_W'(r2), ROW_W'(r1), ROW_W'(r0)};
  endfunction

  function automatic logic [NCOL*ROW_W-1:0] rand_rows(input int maxr);
    logic [NCOL*ROW_W-1:0] v;
    v = '0;
    for (int c = 0; c < NCOL; c++) v[c*ROW_W +: ROW_W] = ROW_W'($urandom_range(maxr, 0));
    return v;
  endfunction

  // drive one cycle of events (bench sits just after a falling edge) and book the outcome
  task automatic put_ev(input logic [NCOL-1:0] v, input logic [NCOL*ROW_W-1:0] rows);
    ev_valid = v;
    ev_row   = rows;
    for (int c = 0; c < NCOL; c++) begin
      if (v[c]) begin
        int r;
        r = int'(rows[c*ROW_W +: ROW_W]);
        if (r < NROW) begin
          if (ev_ready[c]) begin
            exp_cnt[c][r]++;
            acc[c]++;
          end else begin
            exp_drop[c]++;
          end
        end
      end
    end
  endtask

  task automatic ev_cycle(input logic [NCOL-1:0] v, input logic [NCOL*ROW_W-1:0] rows);
    put_ev(v, rows);
    @(negedge clk);
    ev_valid = '0;
  endtask

  task automatic check_drops(input string tag);
    for (int c = 0; c < NCOL; c++)
      check(int'(drop_cnt[c*DROP_W +: DROP_W]) == sat_d(exp_drop[c]),
            $sformatf("R5 drop count col %0d (%s)", c, tag),
            int'(drop_cnt[c*DROP_W +: DROP_W]), sat_d(exp_drop[c]));
  endtask

  task automatic run_frame(input string tag, input bit stress);
    int idx;
    int guard;
    bit stalled;
    logic [CNT_W-1:0] held;
    ev_valid = '0;
    repeat (6) @(negedge clk);
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) begin
        snap[c][r]    = exp_cnt[c][r];
        exp_cnt[c][r] = 0;
      end
    frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
    check(frame_busy == 1'b1, $sformatf("R7 busy after command (%s)", tag), int'(frame_busy), 1);
    idx = 0; guard = 0; stalled = 1'b0; held = '0;
    while (idx < TOTAL && guard < 20000) begin
      guard++;
      if (stalled)
        check(rd_valid && (rd_data == held), $sformatf("R8 held word (%s)", tag),
              int'(rd_data), int'(held));
      rd_ready = ($urandom_range(3, 0) != 0);
      if (stress) begin
        // R9/R5: column 3 floods, column 0 sends an out-of-range row (R4), column 1 one event
        put_ev({1'b1, 1'b0, (guard == 10), 1'b1}, mk_rows(127, 7, 0, 5));
      end else begin
        ev_valid = '0;
      end
      if (rd_valid && rd_ready) begin
        int c;
        int r;
        c = idx / NROW;
        r = idx % NROW;
        check(int'(rd_data) == sat_c(snap[c][r]),
              $sformatf("R2 word %0d col %0d row %0d (%s)", idx, c, r, tag),
              int'(rd_data), sat_c(snap[c][r]));
        if (rd_last != (idx == TOTAL - 1))
          check(1'b0, $sformatf("R7 last marker word %0d (%s)", idx, tag),
                int'(rd_last), int'(idx == TOTAL - 1));
        idx++;
      end
      stalled = rd_valid && !rd_ready;
      held    = rd_data;
      @(negedge clk);
    end
    ev_valid = '0;
    rd_ready = 1'b0;
    check(idx == TOTAL, $sformatf("R7 word count (%s)", tag), idx, TOTAL);
    check(!frame_busy && !rd_valid, $sformatf("R7 idle after frame (%s)", tag),
          int'(frame_busy), 0);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int seed;
    int w;
    int mn;
    int mx;
    seed = int'($urandom(32'h5EED_0017));
    for (int c = 0; c < NCOL; c++) begin
      exp_drop[c] = 0;
      acc[c] = 0;
      for (int r = 0; r < NROW; r++) exp_cnt[c][r] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: clearing sweep
    check(frame_busy == 1'b1, "R1 busy during sweep", int'(frame_busy), 1);
    w = 0;
    while (frame_busy && w < 2000) begin
      w++;
      @(negedge clk);
    end
    check(!frame_busy, "R1 sweep ends", int'(frame_busy), 0);
    check(rd_valid == 1'b0, "R1 no readout word", int'(rd_valid), 0);
    check(ev_ready == '1, "R1 queues ready", int'(ev_ready), (1 << NCOL) - 1);
    check(drop_cnt == '0, "R1 drop counters clear", int'(drop_cnt), 0);
    run_frame("R1 empty frame", 1'b0);

    // directed: back-to-back hits on one counter, edge rows, ignored rows
    for (int k = 0; k < 5; k++) ev_cycle(4'b0001, mk_rows(3, 0, 0, 0));        // R10
    for (int k = 0; k < 3; k++) ev_cycle(4'b0110, mk_rows(0, 112, 111, 0));    // R4 + last row
    ev_cycle(4'b1011, mk_rows(0, 127, 0, 0));
    ev_cycle(4'b0010, mk_rows(0, 120, 0, 0));
    check(ev_ready[1] == 1'b1, "R4 ignored rows leave queue empty", int'(ev_ready[1]), 1);
    check_drops("R4");
    run_frame("R10 directed", 1'b0);

    // random traffic with out-of-range rows mixed in
    for (int k = 0; k < 3000; k++) begin
      logic [NCOL-1:0] v;
      for (int c = 0; c < NCOL; c++) v[c] = ($urandom_range(9, 0) < 4);
      ev_cycle(v, rand_rows(127));
    end
    check_drops("random");
    run_frame("R2 random", 1'b0);

    // R6: all columns request on every clock
    for (int c = 0; c < NCOL; c++) acc[c] = 0;
    for (int k = 0; k < 400; k++) ev_cycle('1, rand_rows(NROW - 1));
    mn = acc[0]; mx = acc[0];
    for (int c = 1; c < NCOL; c++) begin
      if (acc[c] < mn) mn = acc[c];
      if (acc[c] > mx) mx = acc[c];
    end
    check(mx - mn <= 2, "R6 rotating service spread", mx - mn, 2);
    check_drops("R6");
    run_frame("R6 contention", 1'b0);

    // R3: drive one counter past its ceiling
    for (int k = 0; k < 1100; k++) ev_cycle(4'b0100, mk_rows(0, 0, 50, 0));
    ev_cycle(4'b0001, mk_rows(1, 0, 0, 0));
    check(exp_cnt[2][50] > CMAX, "R3 stimulus exceeds ceiling", exp_cnt[2][50], CMAX + 1);
    run_frame("R3 saturation", 1'b0);
    run_frame("R9 cleared after read", 1'b0);

    // R9/R5: events during readout, queue overflow and drop saturation
    run_frame("R9 stress readout", 1'b1);
    check(ev_ready[0] == 1'b1, "R4 out-of-range flood leaves queue free", int'(ev_ready[0]), 1);
    check_drops("R5 stress");
    check(int'(drop_cnt[3*DROP_W +: DROP_W]) == DMAX, "R5 drop counter saturated",
          int'(drop_cnt[3*DROP_W +: DROP_W]), DMAX);
    run_frame("R9 queued events land in next frame", 1'b0);

    // ignored command while busy
    frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
    repeat (3) @(negedge clk);
    frame_req = 1'b1;   // arrives while busy
    @(negedge clk);
    frame_req = 1'b0;
    w = 0;
    rd_ready = 1'b1;
    while (frame_busy && w < 2000) begin
      w++;
      @(negedge clk);
    end
    rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!frame_busy && !rd_valid, "R7 command during readout ignored", int'(frame_busy), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule